// File: doc/BRIEF.md
# Reshapeable Dual-Port RAM

A dual-port memory of 1,152 bits with a write port and a read port, each on its own clock. A two-bit shape input picks how the same storage is seen: 64 words of 18 bits, 128 of 9, 256 of 4 or 512 of 2. Both ports always carry a 9-bit address and an 18-bit data bus. In the narrower shapes only the low address bits that the depth needs are decoded, and only the low data bits that the width needs are used.

The storage is 64 physical rows of 18 bits. A narrow word is a lane inside a row. The low address bits pick the lane and the next six pick the row, so the same bits can be written in one shape and read in another. The read port either registers the selected word on a read-clock edge while read enable is high, or, when the asynchronous-read control is high, follows the read address with no clock edge at all.

Top module: `cfg_dpram`

## Requirements
- R1: While reset is low, and after it is released until the first enabled read-clock edge, `rd_data` is zero with `rd_async` low.
- R2: Shape code 0 gives 64x18, 1 gives 128x9, 2 gives 256x4 and 3 gives 512x2. A word written and then read in the same shape returns its low W bits, where W is the width of that shape.
- R3: Address bits above the ones a shape needs are ignored on both ports. Shape 0 decodes address bits 5..0, shape 1 bits 6..0, shape 2 bits 7..0, and shape 3 all 9 bits.
- R4: The read data bits at and above W are zero. The write data bits at and above W have no effect on storage.
- R5: With `rd_async` low, `rd_data` takes the addressed word on a `rd_clk` rising edge where `rd_en` is high, and holds its value on edges where `rd_en` is low.
- R6: With `rd_async` high, `rd_data` follows `rd_addr` and the stored contents with no `rd_clk` edge.
- R7: Storage changes only on a `wr_clk` rising edge where `wr_en` is high.
- R8: With `rd_async` high and `rd_addr` equal to `wr_addr`, the word written on a `wr_clk` edge appears on `rd_data` right after that edge.
- R9: Physical mapping: in shape s, address a selects row (a >> s) mod 64 and lane a mod 2^s, and the lane occupies row bits starting at lane*W. Data written in one shape reads back through this mapping in any other shape.
- R10: A write in a narrow shape leaves the other lanes of the same row, and all other rows, unchanged.
- R11: All 64 rows of 18 bits hold independent values at once, for 1,152 bits in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| shape | input | 2 | Organisation select (0: 64x18, 1: 128x9, 2: 256x4, 3: 512x2) |
| wr_en | input | 1 | Write enable, sampled on wr_clk |
| wr_addr | input | 9 | Write address |
| wr_data | input | 18 | Write data, low W bits used |
| rd_en | input | 1 | Read enable for the registered read |
| rd_async | input | 1 | High: combinational read; low: registered read |
| rd_addr | input | 9 | Read address |
| rd_data | output | 18 | Read data, zero above the shape width |

## Verification
On every cycle, assertions check that the read register loads the selected lane on enabled edges and holds it on idle edges. They also check that an asynchronous read never shows bits above the current width, and that a write to the address being read asynchronously is visible at the following write-clock edge. The lane arithmetic can only be shown by the bench's scenarios against a bit-level model. This covers cross-shape aliasing of the same physical bits, lane preservation during narrow writes, aliasing of ignored upper address bits, and the full 1,152-bit fill.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;

   localparam int NUM_SHAPES = 4;

   // Shape code s splits a physical row into 2**s lanes.
   typedef enum logic [1:0] {
      SHP_FULL    = 2'd0,
      SHP_HALF    = 2'd1,
      SHP_QUARTER = 2'd2,
      SHP_EIGHTH  = 2'd3
   } shape_e;

   // Width of one lane for a row of word_w bits.
   function automatic int lane_bits(int word_w, logic [1:0] s);
      return word_w / (1 << s);
   endfunction

endpackage

// File: rtl/dpram_lane_map.sv
module dpram_lane_map
   import cfg_dpram_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int WORD_W = 18,
   parameter int ROWS   = 64,
   localparam int ROW_AW = $clog2(ROWS),
   localparam int OFS_W  = $clog2(WORD_W)
) (
   input  logic [ADDR_W-1:0] addr,
   input  shape_e            shp,
   output logic [ROW_AW-1:0] row_o,
   output logic [OFS_W-1:0]  ofs_o,
   output logic [WORD_W-1:0] fmask_o
);

   localparam logic [WORD_W-1:0] ONES = '1;

   if (ADDR_W < ROW_AW + NUM_SHAPES - 1) begin : g_bad_addr
      $error("dpram_lane_map: ADDR_W too small for ROWS and the narrowest shape");
   end
   if (WORD_W < 8) begin : g_bad_word
      $error("dpram_lane_map: WORD_W must allow eight lanes");
   end
   if ((1 << ROW_AW) != ROWS) begin : g_bad_rows
      $error("dpram_lane_map: ROWS must be a power of two");
   end

   logic [ROW_AW-1:0] row_v   [NUM_SHAPES];
   logic [OFS_W-1:0]  ofs_v   [NUM_SHAPES];
   logic [WORD_W-1:0] fmask_v [NUM_SHAPES];

   for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_shape
      localparam int LW = WORD_W / (1 << g);
      localparam logic [WORD_W-1:0] FM = ~(ONES << LW);

      assign row_v[g]   = addr[g +: ROW_AW];
      assign fmask_v[g] = FM;

      if (g == 0) begin : g_single
         assign ofs_v[g] = '0;
      end else begin : g_lanes
         assign ofs_v[g] = OFS_W'(addr[g-1:0]) * OFS_W'(LW);
      end
   end

   always_comb begin
      row_o   = row_v[shp];
      ofs_o   = ofs_v[shp];
      fmask_o = fmask_v[shp];
   end

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
   parameter int WORD_W = 18,
   parameter int ROWS   = 64,
   localparam int ROW_AW = $clog2(ROWS)
) (
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [ROW_AW-1:0] wr_row,
   input  logic [WORD_W-1:0] wr_bmask,
   input  logic [WORD_W-1:0] wr_bits,
   input  logic [ROW_AW-1:0] rd_row,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] mem [ROWS];

   // Read-modify-write of one row: only the lane under the mask changes.
   always_ff @(posedge wr_clk) begin
      if (wr_en) begin
         mem[wr_row] <= (mem[wr_row] & ~wr_bmask) | (wr_bits & wr_bmask);
      end
   end

   assign rd_word = mem[rd_row];

endmodule

// File: rtl/dpram_read_port.sv
module dpram_read_port #(
   parameter int WORD_W = 18,
   localparam int OFS_W = $clog2(WORD_W)
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              rd_async,
   input  logic [WORD_W-1:0] word_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [WORD_W-1:0] fmask_i,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] field;
   logic [WORD_W-1:0] q;

   assign field = (word_i >> ofs_i) & fmask_i;

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (rd_en) begin
         q <= field;
      end
   end

   assign rd_data = rd_async ? field : q;

   // R5: an enabled edge loads the lane that was selected at that edge
   p_capture_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_en |=> (q == $past(field)));

   // R5: an idle edge leaves the register alone
   p_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_en |=> $stable(q));

endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram
   import cfg_dpram_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int WORD_W = 18,
   parameter int ROWS   = 64,
   localparam int ROW_AW = $clog2(ROWS),
   localparam int OFS_W  = $clog2(WORD_W)
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic [1:0]        shape,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_async,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   localparam logic [WORD_W-1:0] ONES = '1;

   shape_e shp;
   assign shp = shape_e'(shape);

   logic [ROW_AW-1:0] w_row, r_row;
   logic [OFS_W-1:0]  w_ofs, r_ofs;
   logic [WORD_W-1:0] w_fmask, r_fmask;
   logic [WORD_W-1:0] w_bmask, w_bits, r_word;

   dpram_lane_map #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROWS(ROWS)) u_wmap (
      .addr(wr_addr), .shp(shp), .row_o(w_row), .ofs_o(w_ofs), .fmask_o(w_fmask)
   );

   dpram_lane_map #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROWS(ROWS)) u_rmap (
      .addr(rd_addr), .shp(shp), .row_o(r_row), .ofs_o(r_ofs), .fmask_o(r_fmask)
   );

   // Place the low lane of the write data at its position in the row.
   assign w_bmask = w_fmask << w_ofs;
   assign w_bits  = (wr_data & w_fmask) << w_ofs;

   dpram_store #(.WORD_W(WORD_W), .ROWS(ROWS)) u_store (
      .wr_clk(wr_clk), .wr_en(wr_en), .wr_row(w_row), .wr_bmask(w_bmask),
      .wr_bits(w_bits), .rd_row(r_row), .rd_word(r_word)
   );

   dpram_read_port #(.WORD_W(WORD_W)) u_rport (
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_async(rd_async),
      .word_i(r_word), .ofs_i(r_ofs), .fmask_i(r_fmask), .rd_data(rd_data)
   );

   // R4: a combinational read shows nothing above the width of the shape
   p_upper_zero_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_async |-> ((rd_data >> lane_bits(WORD_W, shape)) == '0));

   // R8: write to the address being read asynchronously is seen one edge later
   p_async_wr_through_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en && rd_async && (wr_addr == rd_addr)) |=>
      (!rd_async || !$stable(rd_addr) || !$stable(shape) ||
       (rd_data == ($past(wr_data) & ~(ONES << lane_bits(WORD_W, shape))))));

endmodule

// File: tb/tb_cfg_dpram.sv
module tb_cfg_dpram;

   logic        wr_clk = 1'b0;
   logic        rd_clk = 1'b0;
   logic        rst_n  = 1'b0;
   logic [1:0]  shape  = 2'd0;
   logic        wr_en  = 1'b0;
   logic [8:0]  wr_addr = '0;
   logic [17:0] wr_data = '0;
   logic        rd_en  = 1'b0;
   logic        rd_async = 1'b0;
   logic [8:0]  rd_addr = '0;
   logic [17:0] rd_data;

   int tests = 0;
   int fails = 0;
   logic [17:0] model [64];
   logic [17:0] exp_q = '0;

   cfg_dpram dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .shape(shape),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
      .rd_async(rd_async), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // 100 MHz clocks; read clock lags the write clock by 2 ns.
   initial forever #5 wr_clk = ~wr_clk;
   initial begin
      #2;
      forever #5 rd_clk = ~rd_clk;
   end

   function automatic int lw(int s);
      return 18 / (1 << s);
   endfunction

   function automatic logic [17:0] exp_read(int s, logic [8:0] a);
      int row  = (int'(a) >> s) % 64;
      int lane = int'(a) % (1 << s);
      logic [17:0] lmask = ~(18'h3FFFF << lw(s));
      return (model[row] >> (lane * lw(s))) & lmask;
   endfunction

   function automatic void model_write(int s, logic [8:0] a, logic [17:0] d);
      int row  = (int'(a) >> s) % 64;
      int lane = int'(a) % (1 << s);
      logic [17:0] lmask = ~(18'h3FFFF << lw(s));
      logic [17:0] bm = lmask << (lane * lw(s));
      model[row] = (model[row] & ~bm) | (((d & lmask) << (lane * lw(s))) & bm);
   endfunction

   task automatic check(string req, logic [17:0] act, logic [17:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   task automatic do_write(int s, logic [8:0] a, logic [17:0] d, logic en);
      @(negedge wr_clk);
      shape = 2'(s); wr_addr = a; wr_data = d; wr_en = en;
      @(posedge wr_clk);
      #1 wr_en = 1'b0;
      if (en) model_write(s, a, d);
   endtask

   task automatic sync_read(int s, logic [8:0] a, logic en);
      @(negedge wr_clk);
      shape = 2'(s); rd_addr = a; rd_en = en; rd_async = 1'b0;
      if (en) exp_q = exp_read(s, a);
      @(posedge rd_clk);
      #1 rd_en = 1'b0;
   endtask

   task automatic async_read(int s, logic [8:0] a);
      @(negedge wr_clk);
      shape = 2'(s); rd_addr = a; rd_async = 1'b1;
      #1;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      #1_500_000;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      #1;
      // R1: read register is zero during and after reset
      check("R1 in reset", rd_data, 18'h0);
      repeat (3) @(negedge wr_clk);
      rst_n = 1'b1;
      repeat (2) @(posedge rd_clk);
      #1 check("R1 after release", rd_data, 18'h0);

      // R11: fill all 64 full-width rows, read each back
      for (int r = 0; r < 64; r++) do_write(0, 9'(r), 18'($urandom), 1'b1);
      for (int r = 0; r < 64; r++) begin
         sync_read(0, 9'(r), 1'b1);
         check("R11 fill readback", rd_data, exp_q);
      end

      // R2: each shape round-trips a word of its own width
      for (int s = 0; s < 4; s++) begin
         do_write(s, 9'd37, 18'h2A5C3, 1'b1);
         sync_read(s, 9'd37, 1'b1);
         check("R2 shape round trip", rd_data, exp_read(s, 9'd37));
      end

      // R3: upper address bits alias in shape 0 and shape 2
      do_write(0, 9'h005, 18'h1F0E1, 1'b1);
      async_read(0, 9'h1C5);
      check("R3 upper bits ignored shape0", rd_data, 18'h1F0E1);
      do_write(2, 9'h1F3, 18'h0000B, 1'b1);
      async_read(2, 9'h0F3);
      check("R3 upper bit ignored shape2", rd_data, 18'h0000B);

      // R4: wide write data in shape 3 stores 2 bits, reads zero-extended
      do_write(3, 9'd100, 18'h3FFFE, 1'b1);
      async_read(3, 9'd100);
      check("R4 upper read bits zero", rd_data, 18'h00002);
      async_read(3, 9'd101);
      check("R4 neighbour lane untouched", rd_data, exp_read(3, 9'd101));

      // R5: hold on idle edges
      sync_read(1, 9'd10, 1'b1);
      check("R5 enabled capture", rd_data, exp_q);
      do_write(1, 9'd11, ~exp_read(1, 9'd10), 1'b1);
      sync_read(1, 9'd11, 1'b0);
      check("R5 hold without enable", rd_data, exp_q);

      // R6: asynchronous read follows address with no read edge
      @(negedge wr_clk);
      rd_async = 1'b1; shape = 2'd0; rd_addr = 9'd20;
      #1 check("R6 async addr A", rd_data, exp_read(0, 9'd20));
      rd_addr = 9'd21;
      #1 check("R6 async addr B", rd_data, exp_read(0, 9'd21));

      // R7: write with enable low changes nothing
      do_write(0, 9'd22, ~exp_read(0, 9'd22), 1'b0);
      async_read(0, 9'd22);
      check("R7 disabled write", rd_data, exp_read(0, 9'd22));

      // R8: write-through to the address under asynchronous read
      @(negedge wr_clk);
      shape = 2'd0; rd_async = 1'b1; rd_addr = 9'd30;
      wr_addr = 9'd30; wr_data = 18'h15A5A; wr_en = 1'b1;
      @(posedge wr_clk);
      #1 wr_en = 1'b0;
      model_write(0, 9'd30, 18'h15A5A);
      check("R8 write-through", rd_data, 18'h15A5A);

      // R9: full row written, viewed in shapes 1 and 3
      do_write(0, 9'd3, 18'h2D6B5, 1'b1);
      for (int l = 0; l < 8; l++) begin
         async_read(3, 9'(3 * 8 + l));
         check("R9 cross-shape 512x2", rd_data, 18'((18'h2D6B5 >> (2 * l)) & 18'h3));
      end
      async_read(1, 9'd7);
      check("R9 cross-shape 128x9", rd_data, 18'(18'h2D6B5 >> 9));

      // R10: narrow write keeps other lanes of the row
      do_write(2, 9'd29, 18'h00009, 1'b1);
      async_read(0, 9'd7);
      check("R10 other lanes kept", rd_data, model[7]);

      // Random mix over all requirements checked against the model
      for (int i = 0; i < 600; i++) begin
         int s = int'($urandom % 4);
         int op = int'($urandom % 4);
         logic [8:0] a = 9'($urandom);
         case (op)
            0: do_write(s, a, 18'($urandom), 1'($urandom % 4 != 0));
            1: begin
               sync_read(s, a, 1'b1);
               check("R2 R5 random sync", rd_data, exp_q);
            end
            2: begin
               sync_read(s, a, 1'b0);
               check("R5 random hold", rd_data, exp_q);
            end
            default: begin
               async_read(s, a);
               check("R6 R9 random async", rd_data, exp_read(s, a));
            end
         endcase
      end

      summary();
      $finish;
   end

endmodule